// File: doc/BRIEF.md
# Carry-Less Multiply CRC32 Word Engine

This block keeps a 32-bit cyclic redundancy check current over a message that arrives as whole data words, one word on every accepted beat. It never shifts the message through a bit-serial register and never looks anything up in a table. Each word is folded into the running remainder by two carry-less products. The first product multiplies the combined dividend by a precomputed quotient constant to estimate the quotient. The second multiplies that estimate by the generator polynomial, and the low 32 bits of the result are the new remainder. Both constants arrive on input ports, so one instance can serve any 32-bit generator.

Words come in on a valid/ready interface. Each word carries start and end markers and a flag that tells the block whether the word was loaded from little-endian memory. Such a word has its bits in the right order inside each byte, but its bytes run the wrong way across the register. The block reverses the bytes before it combines the word with the remainder. On the starting beat the remainder is taken from a seed input. After the ending beat the finished value appears with a one-cycle done pulse. Bit order is always most significant coefficient first. No output inversion is applied.

Top module: `crcw_engine`

## Requirements
- R1: While `rst` is high, and in the first cycle after a clock edge with `rst` high, `crc_out` is 0, `crc_done` is 0 and `in_ready` is 0.
- R2: After the first clock edge with `rst` low, `in_ready` stays 1 and a word is accepted on every cycle in which `in_valid` is 1.
- R3: On an accepted word with `in_first` = 1, the remainder is seeded from `init_crc`. On any other accepted word, the block continues from the current `crc_out`.
- R4: Each accepted word updates the remainder to ((C·x^64 + D·x^32) mod P), where C is the old remainder and D is the ordered 64-bit word. This equals the result of feeding D's bits, most significant first, into a left-shifting feedback register that XORs in `gen_poly`.
- R5: With `in_le` = 0, bits [63:56] of `in_data` are the earliest message byte and bits [7:0] are the latest. With `in_le` = 1, bits [7:0] are the earliest message byte and bits [63:56] are the latest. Bit 7 of each byte is always its highest-order coefficient.
- R6: `crc_done` is 1 for exactly the one cycle after an accepted word with `in_last` = 1. In that cycle `crc_out` holds the finished remainder. Otherwise `crc_done` is 0.
- R7: In a cycle with `in_valid` low, `in_data`, `in_first`, `in_last` and `in_le` have no effect, and `crc_out` keeps its value.
- R8: A word with both `in_first` and `in_last` set is a complete one-word message.
- R9: A starting word accepted in the cycle right after an ending word begins a new message from `init_crc`. The pulse and result of the previous message are still delivered.
- R10: Any 32-bit generator works when `quot_const` is the low 64 bits of floor(x^96 / (x^32 + `gen_poly`)).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Word present on `in_data` |
| in_ready | output | 1 | Block can take a word this cycle |
| in_data | input | 64 | Message word |
| in_first | input | 1 | Word starts a message |
| in_last | input | 1 | Word ends a message |
| in_le | input | 1 | Word was loaded from little-endian memory; reverse its bytes |
| init_crc | input | 32 | Seed remainder used on a starting word |
| gen_poly | input | 32 | Generator polynomial without its x^32 term |
| quot_const | input | 64 | Barrett quotient constant without its x^64 term |
| crc_out | output | 32 | Running or finished remainder |
| crc_done | output | 1 | Pulse: `crc_out` holds a finished message result |

## Verification
The case that matters most is a completion and a fresh start landing in the same cycle. The ending word of one message is followed straight away by the starting word of the next, so the done pulse and result of the first message are on the outputs at the very moment the next message's seed is being applied. The bench sends two two-word messages back to back with different seeds. In the cycle where the second message starts, it checks that `crc_done` is 1 and `crc_out` equals the first message's reference value. At the end of the second message it checks that message's own reference value. Every reference value comes from a bit-serial feedback model inside the bench, using a quotient constant that the bench derives by long division.

// File: rtl/crcw_pkg.sv
package crcw_pkg;

    localparam int CRC_W      = 32;
    localparam int WORD_W_DEF = 64;
    localparam int BYTE_W     = 8;

    // How the bytes of an incoming word relate to message order
    typedef enum logic {
        ORDER_POLY   = 1'b0,   // already polynomial order: top byte first
        ORDER_LE_MEM = 1'b1    // loaded from little-endian memory: bottom byte first
    } word_order_e;

    typedef struct packed {
        logic [CRC_W-1:0] crc;
        logic             done;
    } crcw_result_t;

endpackage

// File: rtl/crcw_byteorder.sv
module crcw_byteorder
    import crcw_pkg::*;
#(
    parameter int W = WORD_W_DEF
) (
    input  logic [W-1:0] din,
    input  word_order_e  order,
    output logic [W-1:0] dout
);
    localparam int NBYTES = W / BYTE_W;

    logic [W-1:0] reversed;

    // Mirror byte lanes; bits inside each lane keep their position
    for (genvar k = 0; k < NBYTES; k++) begin : g_lane
        assign reversed[k*BYTE_W +: BYTE_W] = din[(NBYTES-1-k)*BYTE_W +: BYTE_W];
    end

    assign dout = (order == ORDER_LE_MEM) ? reversed : din;

endmodule

// File: rtl/crcw_clmul.sv
// Carry-less product of a and b; only bits [LO +: OW] of it are produced.
module crcw_clmul #(
    parameter int AW = 64,
    parameter int BW = 64,
    parameter int LO = 0,
    parameter int OW = AW + BW - 1
) (
    input  logic [AW-1:0] a,
    input  logic [BW-1:0] b,
    output logic [OW-1:0] p
);
    for (genvar j = 0; j < OW; j++) begin : g_bit
        localparam int N = LO + j;
        always_comb begin
            logic acc;
            acc = 1'b0;
            for (int i = 0; i < AW; i++) begin
                if ((N - i) >= 0 && (N - i) < BW) begin
                    acc = acc ^ (a[i] & b[N - i]);
                end
            end
            p[j] = acc;
        end
    end

endmodule

// File: rtl/crcw_barrett.sv
// remainder = (dividend * x^32) mod (x^32 + poly), via two carry-less products
module crcw_barrett
    import crcw_pkg::*;
#(
    parameter int W = WORD_W_DEF
) (
    input  logic [W-1:0]     dividend,
    input  logic [W-1:0]     quot_const,
    input  logic [CRC_W-1:0] poly,
    output logic [CRC_W-1:0] remainder
);
    localparam int HI_W = W - 1;

    logic [HI_W-1:0] prod_hi;
    logic [W-1:0]    quotient;

    // Upper part of dividend * quot_const
    crcw_clmul #(.AW(W), .BW(W), .LO(W), .OW(HI_W)) u_est (
        .a (dividend),
        .b (quot_const),
        .p (prod_hi)
    );

    // Implicit x^W term of the constant adds the dividend itself
    assign quotient = {1'b0, prod_hi} ^ dividend;

    // The x^32 term of the generator only affects bits above the remainder
    crcw_clmul #(.AW(W), .BW(CRC_W), .LO(0), .OW(CRC_W)) u_fold (
        .a (quotient),
        .b (poly),
        .p (remainder)
    );

endmodule

// File: rtl/crcw_engine.sv
module crcw_engine
    import crcw_pkg::*;
#(
    parameter int W = WORD_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [W-1:0]     in_data,
    input  logic             in_first,
    input  logic             in_last,
    input  logic             in_le,
    input  logic [CRC_W-1:0] init_crc,
    input  logic [CRC_W-1:0] gen_poly,
    input  logic [W-1:0]     quot_const,
    output logic [CRC_W-1:0] crc_out,
    output logic             crc_done
);
    localparam int PAD = W - CRC_W;

    logic             ready_q;
    crcw_result_t     res_q;
    logic             accept;
    logic [W-1:0]     ordered;
    logic [CRC_W-1:0] crc_base;
    logic [W-1:0]     dividend;
    logic [CRC_W-1:0] crc_next;
    word_order_e      order;

    assign order  = word_order_e'(in_le);
    assign accept = in_valid && ready_q;

    crcw_byteorder #(.W(W)) u_order (
        .din   (in_data),
        .order (order),
        .dout  (ordered)
    );

    assign crc_base = in_first ? init_crc : res_q.crc;

    if (PAD == 0) begin : g_narrow
        assign dividend = crc_base ^ ordered;
    end else begin : g_wide
        assign dividend = {crc_base, {PAD{1'b0}}} ^ ordered;
    end

    crcw_barrett #(.W(W)) u_reduce (
        .dividend   (dividend),
        .quot_const (quot_const),
        .poly       (gen_poly),
        .remainder  (crc_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ready_q <= 1'b0;
            res_q   <= '0;
        end else begin
            ready_q    <= 1'b1;
            res_q.done <= accept && in_last;
            if (accept) begin
                res_q.crc <= crc_next;
            end
        end
    end

    assign in_ready = ready_q;
    assign crc_out  = res_q.crc;
    assign crc_done = res_q.done;

endmodule

// File: rtl/crcw_engine_chk.sv
module crcw_engine_chk
    import crcw_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             in_last,
    input logic [CRC_W-1:0] crc_out,
    input logic             crc_done
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!in_ready && !crc_done && crc_out == '0));

    assert_ready_held_R2: assert property (@(posedge clk) disable iff (rst)
        !rst |=> in_ready);

    assert_done_after_last_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_last) |=> crc_done);

    assert_done_only_from_last_R6: assert property (@(posedge clk) disable iff (rst)
        crc_done |-> $past(in_valid && in_ready && in_last));

    assert_idle_holds_R7: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_ready) |=> $stable(crc_out));

endmodule

bind crcw_engine crcw_engine_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_last  (in_last),
    .crc_out  (crc_out),
    .crc_done (crc_done)
);

// File: tb/crcw_engine_test.sv
module crcw_engine_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_data = '0;
    logic        in_first = 1'b0;
    logic        in_last = 1'b0;
    logic        in_le = 1'b0;
    logic [31:0] init_crc = '0;
    logic [31:0] gen_poly = '0;
    logic [63:0] quot_const = '0;
    logic [31:0] crc_out;
    logic        crc_done;

    int checks = 0;
    int errors = 0;

    logic [7:0] msg_a [32];
    logic [7:0] msg_b [32];

    always #2.5 clk = ~clk;   // 200 MHz

    crcw_engine uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_first(in_first), .in_last(in_last), .in_le(in_le),
        .init_crc(init_crc), .gen_poly(gen_poly), .quot_const(quot_const),
        .crc_out(crc_out), .crc_done(crc_done)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Low 64 bits of floor(x^96 / (x^32 + poly)) by long division
    function automatic logic [63:0] calc_mu(input logic [31:0] poly);
        logic [96:0] cur;
        logic [64:0] q;
        cur = '0;
        cur[96] = 1'b1;
        q = '0;
        for (int i = 96; i >= 32; i--) begin
            if (cur[i]) begin
                q[i-32] = 1'b1;
                cur = cur ^ ({64'b0, 1'b1, poly} << (i - 32));
            end
        end
        return q[63:0];
    endfunction

    // Bit-serial MSB-first feedback register model
    function automatic logic [31:0] ref_crc(input logic [7:0] m [32], input int nbytes,
                                            input logic [31:0] init, input logic [31:0] poly);
        logic [31:0] c;
        logic        fb;
        c = init;
        for (int i = 0; i < nbytes; i++) begin
            for (int b = 7; b >= 0; b--) begin
                fb = c[31] ^ m[i][b];
                c  = c << 1;
                if (fb) c = c ^ poly;
            end
        end
        return c;
    endfunction

    function automatic logic [63:0] pack_word(input logic [7:0] m [32], input int w, input bit le);
        logic [63:0] word;
        for (int k = 0; k < 8; k++) begin
            if (le) word[8*k +: 8] = m[w*8 + k];
            else    word[63-8*k -: 8] = m[w*8 + k];
        end
        return word;
    endfunction

    task automatic drive(input logic [63:0] d, input bit f, input bit l, input bit le);
        in_valid = 1'b1;
        in_data  = d;
        in_first = f;
        in_last  = l;
        in_le    = le;
    endtask

    task automatic idle_garbage(input int seed);
        in_valid = 1'b0;
        in_data  = {32'hDEAD_0000 + seed, 32'h5A5A_A5A5};
        in_first = 1'b1;
        in_last  = 1'b1;
        in_le    = seed[0];
    endtask

    // One message; optional idle cycles after the first word
    task automatic run_msg(input logic [7:0] m [32], input int nwords, input bit le,
                           input logic [31:0] init, input logic [31:0] poly,
                           input int gap, input string req);
        logic [31:0] exp;
        logic [31:0] held;
        exp = ref_crc(m, nwords*8, init, poly);
        init_crc   = init;
        gen_poly   = poly;
        quot_const = calc_mu(poly);
        for (int w = 0; w < nwords; w++) begin
            @(negedge clk);
            if (w > 0) chk(crc_done == 1'b0, {req, " R6 no pulse mid-message"}, {31'b0, crc_done}, 32'h0);
            if (w == 1 && gap > 0) begin
                idle_garbage(w);
                @(negedge clk);
                held = crc_out;
                for (int g = 1; g < gap; g++) begin
                    idle_garbage(g + 7);
                    @(negedge clk);
                end
                chk(crc_out == held, {req, " R7 idle holds"}, crc_out, held);
                chk(crc_done == 1'b0, {req, " R7 idle no pulse"}, {31'b0, crc_done}, 32'h0);
            end
            drive(pack_word(m, w, le), w == 0, w == nwords - 1, le);
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk(crc_done == 1'b1, {req, " R6 done pulse"}, {31'b0, crc_done}, 32'h1);
        chk(crc_out == exp, {req, " R4 result"}, crc_out, exp);
        @(negedge clk);
        chk(crc_done == 1'b0, {req, " R6 pulse one cycle"}, {31'b0, crc_done}, 32'h0);
        chk(crc_out == exp, {req, " R7 result held"}, crc_out, exp);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(in_ready == 1'b0, "R1 ready low in reset", {31'b0, in_ready}, 32'h0);
        chk(crc_done == 1'b0, "R1 done low in reset", {31'b0, crc_done}, 32'h0);
        chk(crc_out == 32'h0, "R1 crc zero in reset", crc_out, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(in_ready == 1'b1, "R2 ready after reset", {31'b0, in_ready}, 32'h1);
    endtask

    task automatic t_check_vector();
        logic [31:0] r;
        for (int i = 0; i < 32; i++) msg_a[i] = (i < 9) ? 8'(8'h31 + i) : 8'h00;
        r = ref_crc(msg_a, 9, 32'hFFFF_FFFF, 32'h04C1_1DB7);
        chk(r == 32'h0376_E6E7, "R4 model check vector", r, 32'h0376_E6E7);
        run_msg(msg_a, 2, 1'b1, 32'hFFFF_FFFF, 32'h04C1_1DB7, 0, "R5 le check vector");
        run_msg(msg_a, 2, 1'b0, 32'hFFFF_FFFF, 32'h04C1_1DB7, 0, "R5 poly-order check vector");
    endtask

    task automatic t_long_msg();
        for (int i = 0; i < 32; i++) msg_a[i] = 8'(i * 37 + 11);
        run_msg(msg_a, 4, 1'b0, 32'h1234_5678, 32'h04C1_1DB7, 0, "R2 R3 four words");
        run_msg(msg_a, 4, 1'b1, 32'h0, 32'h04C1_1DB7, 3, "R7 gap mid-message");
    endtask

    task automatic t_single();
        for (int i = 0; i < 32; i++) msg_a[i] = 8'(8'hF0 ^ (i * 5));
        run_msg(msg_a, 1, 1'b0, 32'hA5A5_0F0F, 32'h04C1_1DB7, 0, "R8 single word");
    endtask

    task automatic t_back_to_back();
        logic [31:0] ea, eb;
        for (int i = 0; i < 32; i++) begin
            msg_a[i] = 8'(i * 13 + 3);
            msg_b[i] = 8'(8'h99 - i * 7);
        end
        ea = ref_crc(msg_a, 16, 32'hFFFF_FFFF, 32'h04C1_1DB7);
        eb = ref_crc(msg_b, 16, 32'h0BAD_F00D, 32'h04C1_1DB7);
        gen_poly   = 32'h04C1_1DB7;
        quot_const = calc_mu(32'h04C1_1DB7);
        init_crc   = 32'hFFFF_FFFF;
        @(negedge clk);
        drive(pack_word(msg_a, 0, 0), 1, 0, 0);
        @(negedge clk);
        drive(pack_word(msg_a, 1, 0), 0, 1, 0);
        @(negedge clk);
        chk(crc_done == 1'b1, "R9 first message pulse", {31'b0, crc_done}, 32'h1);
        chk(crc_out == ea, "R9 first message result", crc_out, ea);
        init_crc = 32'h0BAD_F00D;
        drive(pack_word(msg_b, 0, 1), 1, 0, 1);
        @(negedge clk);
        chk(crc_done == 1'b0, "R9 no pulse after new start", {31'b0, crc_done}, 32'h0);
        drive(pack_word(msg_b, 1, 1), 0, 1, 1);
        @(negedge clk);
        in_valid = 1'b0;
        chk(crc_done == 1'b1, "R9 second message pulse", {31'b0, crc_done}, 32'h1);
        chk(crc_out == eb, "R9 R3 second message reseeded", crc_out, eb);
    endtask

    task automatic t_other_poly();
        for (int i = 0; i < 32; i++) msg_a[i] = 8'(i * i + 1);
        run_msg(msg_a, 3, 1'b0, 32'hFFFF_FFFF, 32'h1EDC_6F41, 0, "R10 second generator");
        run_msg(msg_a, 2, 1'b1, 32'h0000_0001, 32'h8141_AB1F, 0, "R10 third generator");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_check_vector();
        t_long_msg();
        t_single();
        t_back_to_back();
        t_other_poly();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule